// File: doc/BRIEF.md
# Address Window Decoder

This block maps a 32-bit bus address to a target unit through a small bank of programmable windows. Each window has a base address and a size mask, both at 64 KB granularity, and an 8-bit target attribute that names the unit behind the window. Typical attributes are 0x1E for on-chip SRAM and 0x0E, 0x0D, 0x0B or 0x07 for DRAM chip-selects 0 to 3. In each of the DRAM codes exactly one low-active select bit is cleared. A single shared control word holds one enable bit per window and one 2-bit access-permission field per window.

A register write port programs the windows. Lookups are purely combinational. In the same cycle as the request, the block reports whether a window hits, which window it is, the target attribute, a permission-violation flag and a decode error. The default parameters give five windows: four DRAM chip-selects plus one SRAM window.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset every register is zero, so every window is disabled and a valid lookup reports an error with no hit.
- R2: A window matches when `(lk_addr[31:16] & ~mask[31:16]) == (base[31:16] & ~mask[31:16])`. A mask of 0x03FF0000 therefore spans 64 MB and a mask of 0x0FFF0000 spans 256 MB.
- R3: Window i takes part in decoding only while bit i of the control word is 1.
- R4: Window i's permission field is at control bits [17+2i:16+2i]. Field bit 0 allows reads and field bit 1 allows writes, so the value 3 grants full access.
- R5: When several enabled windows match, the lowest-numbered one is selected.
- R6: On a hit, `lk_win` gives the selected window and `lk_attr` gives bits [15:8] of that window's base register.
- R7: When the selected window lacks the permission for the access direction, `lk_viol` is 1 and `lk_hit` and `lk_err` are 0. `lk_win` still names the window and `lk_attr` is 0.
- R8: When no enabled window matches a valid lookup, `lk_err` is 1 and `lk_hit`, `lk_viol`, `lk_win` and `lk_attr` are all 0.
- R9: Results appear in the same cycle as the request. While `lk_valid` is 0, all lookup outputs are 0.
- R10: A write with `cfg_sel` = 0 loads the control word, 1 loads window `cfg_win`'s base and attribute, and 2 loads its mask. Code 3, and any `cfg_win` of `NUM_WIN` or above, changes nothing. A write takes effect from the clock edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register kind: 0 control, 1 base, 2 mask |
| cfg_win | input | WIN_W | Window addressed by a base or mask write |
| cfg_wdata | input | 32 | Write data |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a write access |
| lk_addr | input | 32 | Address to decode |
| lk_hit | output | 1 | Permitted match found |
| lk_win | output | WIN_W | Selected window |
| lk_attr | output | 8 | Target attribute of the selected window |
| lk_viol | output | 1 | Access direction not permitted |
| lk_err | output | 1 | No enabled window matches |

## Verification
The bench builds the decoder with the default five windows, so `WIN_W` is 3. This leaves window codes 5 to 7 addressable but absent, which lets the bench check that writes aimed at them are dropped. Five windows are enough to lay a 256 MB DRAM region over a smaller window for the priority check, to place an SRAM window exactly at its 64 MB edge, and to keep one window disabled while its neighbours decode.

// File: rtl/awd_pkg.sv
package awd_pkg;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_BASE = 2'd1;
  localparam logic [1:0] SEL_MASK = 2'd2;

  // Control word layout: enables from bit 0, permission pairs from bit 16
  localparam int PERM_LSB = 16;

  typedef struct packed {
    logic [15:0] base;
    logic [7:0]  attr;
    logic [15:0] mask;
  } win_cfg_t;

  // 64 KB granular compare: mask bits set to 1 are don't-care
  function automatic logic win_hit(logic [15:0] a_hi, logic [15:0] base,
                                   logic [15:0] mask);
    return ((a_hi ^ base) & ~mask) == 16'h0000;
  endfunction

  // bit 0 allows reads, bit 1 allows writes
  function automatic logic perm_ok(logic [1:0] perm, logic is_wr);
    return is_wr ? perm[1] : perm[0];
  endfunction

endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
  import awd_pkg::*;
#(
  parameter int NUM_WIN = 5,
  parameter int WIN_W   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [1:0]           sel,
  input  logic [WIN_W-1:0]     win,
  input  logic [31:0]          wdata,
  output logic [NUM_WIN-1:0]   en,
  output logic [2*NUM_WIN-1:0] perm,
  output win_cfg_t             cfg [NUM_WIN]
);

  logic ctrl_we;
  assign ctrl_we = we && (sel == SEL_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= '0;
      perm <= '0;
    end else if (ctrl_we) begin
      en   <= wdata[NUM_WIN-1:0];
      perm <= wdata[PERM_LSB +: 2*NUM_WIN];
    end
  end

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    logic me;
    assign me = we && (win == WIN_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg[g] <= '0;
      end else if (me && sel == SEL_BASE) begin
        cfg[g].base <= wdata[31:16];
        cfg[g].attr <= wdata[15:8];
      end else if (me && sel == SEL_MASK) begin
        cfg[g].mask <= wdata[31:16];
      end
    end
  end

  logic unused_wd;
  assign unused_wd = ^wdata;

  // R1: registers come out of reset cleared
  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (en == '0 && perm == '0));

  // R10: control word only changes on a control write
  a_r10_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_we |=> ($stable(en) && $stable(perm)));

endmodule

// File: rtl/awd_window_cmp.sv
module awd_window_cmp
  import awd_pkg::*;
#(
  parameter int NUM_WIN = 5
) (
  input  logic [15:0]        addr_hi,
  input  logic [NUM_WIN-1:0] en,
  input  win_cfg_t           cfg [NUM_WIN],
  output logic [NUM_WIN-1:0] match
);

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
    assign match[g] = en[g] && win_hit(addr_hi, cfg[g].base, cfg[g].mask);
  end

endmodule

// File: rtl/awd_priority.sv
module awd_priority #(
  parameter int NUM_WIN = 5,
  parameter int WIN_W   = 3
) (
  input  logic [NUM_WIN-1:0] req,
  output logic               any,
  output logic [WIN_W-1:0]   idx
);

  // Scan from the top so the lowest set bit is the last one to land
  always_comb begin
    idx = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (req[i]) idx = WIN_W'(i);
    end
  end

  assign any = |req;

endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
  import awd_pkg::*;
#(
  parameter int NUM_WIN = 5,
  localparam int WIN_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [WIN_W-1:0] cfg_win,
  input  logic [31:0]      cfg_wdata,
  input  logic             lk_valid,
  input  logic             lk_write,
  input  logic [31:0]      lk_addr,
  output logic             lk_hit,
  output logic [WIN_W-1:0] lk_win,
  output logic [7:0]       lk_attr,
  output logic             lk_viol,
  output logic             lk_err
);

  // NUM_WIN may range from 1 to 8 so the control word fields fit
  logic [NUM_WIN-1:0]   win_en;
  logic [2*NUM_WIN-1:0] win_perm;
  win_cfg_t             win_cfg [NUM_WIN];
  logic [NUM_WIN-1:0]   match_vec;
  logic                 match_any;
  logic [WIN_W-1:0]     match_idx;
  logic [1:0]           sel_perm;
  logic [7:0]           sel_attr;
  logic                 access_ok;

  awd_regfile #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .sel   (cfg_sel),
    .win   (cfg_win),
    .wdata (cfg_wdata),
    .en    (win_en),
    .perm  (win_perm),
    .cfg   (win_cfg)
  );

  awd_window_cmp #(.NUM_WIN(NUM_WIN)) u_cmp (
    .addr_hi (lk_addr[31:16]),
    .en      (win_en),
    .cfg     (win_cfg),
    .match   (match_vec)
  );

  awd_priority #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) u_prio (
    .req (match_vec),
    .any (match_any),
    .idx (match_idx)
  );

  always_comb begin
    sel_perm = 2'b00;
    sel_attr = 8'h00;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (match_idx == WIN_W'(i)) begin
        sel_perm = win_perm[2*i +: 2];
        sel_attr = win_cfg[i].attr;
      end
    end
  end

  assign access_ok = perm_ok(sel_perm, lk_write);

  assign lk_hit  = lk_valid && match_any && access_ok;
  assign lk_viol = lk_valid && match_any && !access_ok;
  assign lk_err  = lk_valid && !match_any;
  assign lk_win  = (lk_valid && match_any) ? match_idx : '0;
  assign lk_attr = lk_hit ? sel_attr : 8'h00;

  logic unused_addr;
  assign unused_addr = ^lk_addr[15:0];

  // R9: quiet outputs while idle
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> (!lk_hit && !lk_viol && !lk_err && lk_attr == 8'h00));

  // R7, R8: outcomes are mutually exclusive
  a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lk_hit, lk_viol, lk_err}));

  // R8: an error only when no window compare fired
  a_r8_err_no_match: assert property (@(posedge clk) disable iff (!rst_n)
    lk_err |-> (match_vec == '0));

  // R5: the reported window matches and no lower window does
  a_r5_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit || lk_viol) |->
      ((((match_vec >> lk_win) & NUM_WIN'(1)) != '0) &&
       ((match_vec & ((NUM_WIN'(1) << lk_win) - NUM_WIN'(1))) == '0)));

endmodule

// File: tb/addr_window_decoder_tb.sv
`timescale 1ns/1ps
module addr_window_decoder_tb;

  localparam int NW = 5;
  localparam int WW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = 2'd0;
  logic [WW-1:0] cfg_win = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          lk_valid = 1'b0;
  logic          lk_write = 1'b0;
  logic [31:0]   lk_addr = '0;
  logic          lk_hit;
  logic [WW-1:0] lk_win;
  logic [7:0]    lk_attr;
  logic          lk_viol;
  logic          lk_err;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  addr_window_decoder #(.NUM_WIN(NW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_win(cfg_win), .cfg_wdata(cfg_wdata), .lk_valid(lk_valid),
    .lk_write(lk_write), .lk_addr(lk_addr), .lk_hit(lk_hit),
    .lk_win(lk_win), .lk_attr(lk_attr), .lk_viol(lk_viol), .lk_err(lk_err)
  );

  typedef struct {
    logic          hit;
    logic [WW-1:0] win;
    logic [7:0]    attr;
    logic          viol;
    logic          err;
    string         tag;
  } exp_t;

  exp_t sb [$];

  // Monitor: compare one expected item per falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_checks++;
        if (lk_hit !== e.hit || lk_win !== e.win || lk_attr !== e.attr ||
            lk_viol !== e.viol || lk_err !== e.err) begin
          n_fails++;
          $display("FAIL %s: got hit=%0b win=%0d attr=%02h viol=%0b err=%0b, expected hit=%0b win=%0d attr=%02h viol=%0b err=%0b",
                   e.tag, lk_hit, lk_win, lk_attr, lk_viol, lk_err,
                   e.hit, e.win, e.attr, e.viol, e.err);
        end
      end
    end
  end

  task automatic cfg_write(input logic [1:0] s, input logic [WW-1:0] w,
                           input logic [31:0] d);
    @(posedge clk); #1;
    lk_valid  = 1'b0;
    cfg_we    = 1'b1;
    cfg_sel   = s;
    cfg_win   = w;
    cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we    = 1'b0;
  endtask

  task automatic look(input logic v, input logic wr, input logic [31:0] a,
                      input logic eh, input int ew, input logic [7:0] ea,
                      input logic ev, input logic ee, input string tag);
    exp_t e;
    @(posedge clk); #1;
    lk_valid = v;
    lk_write = wr;
    lk_addr  = a;
    e.hit = eh; e.win = WW'(ew); e.attr = ea; e.viol = ev; e.err = ee;
    e.tag = tag;
    sb.push_back(e);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: cleared after reset
    look(1, 0, 32'h0000_0000, 0, 0, 8'h00, 0, 1, "R1 reset lookup errs");
    look(1, 1, 32'h4000_0000, 0, 0, 8'h00, 0, 1, "R1 reset write lookup errs");

    // Program windows (R10): DRAM cs0..cs2, small overlay, SRAM
    cfg_write(2'd1, 3'd0, 32'h0000_0E00);
    cfg_write(2'd2, 3'd0, 32'h0FFF_0000);
    cfg_write(2'd1, 3'd1, 32'h1000_0D00);
    cfg_write(2'd2, 3'd1, 32'h0FFF_0000);
    cfg_write(2'd1, 3'd2, 32'h2000_0B00);
    cfg_write(2'd2, 3'd2, 32'h0FFF_0000);
    cfg_write(2'd1, 3'd3, 32'h0800_0700);
    cfg_write(2'd2, 3'd3, 32'h00FF_0000);
    cfg_write(2'd1, 3'd4, 32'h4000_1E00);
    cfg_write(2'd2, 3'd4, 32'h03FF_0000);
    // enable 0,1,4; perm w0=3, w1=1 (read only), w4=3
    cfg_write(2'd0, 3'd0, 32'h0307_0013);

    look(1, 0, 32'h0123_4567, 1, 0, 8'h0E, 0, 0, "R2 R6 cs0 window");
    look(1, 0, 32'h1FFF_FFFF, 1, 1, 8'h0D, 0, 0, "R2 R6 cs1 upper edge");
    look(1, 1, 32'h1000_0000, 0, 1, 8'h00, 1, 0, "R7 R4 write to read-only");
    look(1, 0, 32'h43FF_FFFF, 1, 4, 8'h1E, 0, 0, "R2 SRAM 64MB last byte");
    look(1, 0, 32'h4400_0000, 0, 0, 8'h00, 0, 1, "R8 R2 past SRAM window");
    look(1, 0, 32'h2000_0000, 0, 0, 8'h00, 0, 1, "R3 disabled window errs");
    look(1, 0, 32'h0800_0000, 1, 0, 8'h0E, 0, 0, "R3 disabled overlay ignored");
    look(0, 0, 32'h0800_0000, 0, 0, 8'h00, 0, 0, "R9 idle outputs zero");

    // enable all, full permission
    cfg_write(2'd0, 3'd0, 32'h03FF_001F);
    look(1, 0, 32'h0800_1234, 1, 0, 8'h0E, 0, 0, "R5 lowest window wins");
    look(1, 1, 32'h2345_0000, 1, 2, 8'h0B, 0, 0, "R3 R4 cs2 write allowed");
    look(1, 1, 32'h1000_0000, 1, 1, 8'h0D, 0, 0, "R4 value 3 allows write");

    // window 0 write-only
    cfg_write(2'd0, 3'd0, 32'h03FE_001F);
    look(1, 0, 32'h0000_1000, 0, 0, 8'h00, 1, 0, "R4 R7 read to write-only");
    look(1, 1, 32'h0000_1000, 1, 0, 8'h0E, 0, 0, "R4 write to write-only");

    // disable window 0: overlay takes over
    cfg_write(2'd0, 3'd0, 32'h03FF_001E);
    look(1, 0, 32'h0800_0000, 1, 3, 8'h07, 0, 0, "R5 R3 overlay after cs0 off");
    look(1, 0, 32'h0000_1000, 0, 0, 8'h00, 0, 1, "R8 cs0 off errs");

    // writes that must change nothing (R10)
    cfg_write(2'd1, 3'd5, 32'hFFFF_FF00);
    cfg_write(2'd2, 3'd7, 32'hFFFF_0000);
    cfg_write(2'd3, 3'd3, 32'h0000_0000);
    look(1, 0, 32'h0800_0000, 1, 3, 8'h07, 0, 0, "R10 ignored writes");
    look(1, 0, 32'h9000_0000, 0, 0, 8'h00, 0, 1, "R10 no window at 0x9");

    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule